// File: doc/BRIEF.md
# Rotating-Diagonal Wavefront Allocator

This block matches N requesters to N resources in one combinational pass. The caller presents an N by N request matrix on `req`. Bit `i*N + j` is set when requester i wants resource j. The block returns a grant matrix of the same layout on `grant`. The matrix never holds more than one grant in any row or in any column. Row and column decisions are made together, not in two passes. Each row and each column owns one token. Both tokens start at the cells of a priority diagonal. A requesting cell that holds both its row token and its column token wins and keeps both tokens. Any other cell hands its row token one cell to the right and its column token one cell down. Both moves wrap modulo N.

Passing the tokens right and down moves them from diagonal k, the cells where (i+j) mod N equals k, to diagonal k+1. The block therefore visits the diagonals in order, starting at the priority diagonal. A registered pointer selects the priority diagonal. The pointer has two modes. In HOLD (`enable` low) it keeps its value. In STEP (`enable` high) it moves forward one place at the clock edge, with the transition from N-1 going back to 0. Reset puts the pointer at 0. A registered copy of the grants, `grant_q`, serves callers that register the result before using it.

Top module: `wavefront_alloc`

## Requirements
- R1: At most one bit of `grant` is set within each row (bits i*N to i*N+N-1).
- R2: At most one bit of `grant` is set among the cells of any single column j.
- R3: A grant bit is set only where the matching request bit is set.
- R4: A requested cell is left without a grant only when another cell in its row, or another cell in its column, holds a grant.
- R5: Every requested cell on the priority diagonal, (i+j) mod N equal to the pointer, is granted.
- R6: With N=4, pointer 0, and requests {0,1,2}, {0,1}, {0}, {0,2} for requesters 0 to 3, the grants are [0,0], [1,1] and [3,2].
- R7: The pointer is 0 after reset. It steps by one, modulo N, at each rising edge where `enable` is high, and it holds otherwise.
- R8: `grant_q` is zero during reset and afterwards equals the `grant` value from the previous clock edge.
- R9: After the priority diagonal p, the diagonals are served in the order p+1, p+2 and so on modulo N. Tokens that leave the last column or row continue at column or row 0.
- R10: Within a cycle, `grant` depends only on `req` and the pointer. A change on `enable` does not alter it before the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Advance the priority diagonal at this edge |
| req | input | N*N | Request matrix, bit i*N+j is requester i to resource j |
| grant | output | N*N | Combinational grant matrix, same layout |
| grant_q | output | N*N | Grant matrix registered at the clock edge |

## Verification
Every cycle, the assertions check the row and column exclusivity of the grants, that each grant sits on a request, that the match is maximal, that the priority diagonal is always served, that the pointer steps and holds correctly, and that the registered copy is correct. Only the bench scenarios can show the exact match that a given diagonal order produces. These include the worked example, rotation through every diagonal under full and single-column loads, wrap of the tokens past the last column, and pointer reset in the middle of a run.

// File: rtl/wfa_pkg.sv
package wfa_pkg;

    // Pointer controller modes.
    typedef enum logic {
        DIAG_HOLD = 1'b0,
        DIAG_STEP = 1'b1
    } diag_mode_e;

    // Modular sum used for diagonal and column indexing.
    function automatic int wrap_add(input int a, input int b, input int n);
        return (a + b) % n;
    endfunction

endpackage

// File: rtl/wfa_diag_ptr.sv
module wfa_diag_ptr
    import wfa_pkg::*;
#(
    parameter int N = 4,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    output logic [IW-1:0] ptr
);

    diag_mode_e    mode;
    logic [IW-1:0] ptr_nxt;

    always_comb begin
        mode = enable ? DIAG_STEP : DIAG_HOLD;
    end

    always_comb begin
        unique case (mode)
            DIAG_HOLD: ptr_nxt = ptr;
            DIAG_STEP: ptr_nxt = (ptr == IW'(N - 1)) ? '0 : ptr + 1'b1;
            default:   ptr_nxt = ptr;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr <= '0;
        else        ptr <= ptr_nxt;
    end

    // R7
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> $stable(ptr));

    // R7
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && ptr != IW'(N - 1)) |=> (ptr == $past(ptr) + 1'b1));

    // R7
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && ptr == IW'(N - 1)) |=> (ptr == '0));

endmodule

// File: rtl/wfa_diag_stage.sv
module wfa_diag_stage
    import wfa_pkg::*;
#(
    parameter int N = 4,
    localparam int IW = $clog2(N),
    localparam int CELLS = N * N
) (
    input  logic [IW-1:0]    diag,
    input  logic [CELLS-1:0] req,
    input  logic [N-1:0]     row_tok_in,
    input  logic [N-1:0]     col_tok_in,
    output logic [CELLS-1:0] stage_grant,
    output logic [N-1:0]     row_tok_out,
    output logic [N-1:0]     col_tok_out
);

    // The cells of one diagonal lie in different rows and columns.
    // They decide in parallel, with no conflict between them.
    always_comb begin
        stage_grant = '0;
        row_tok_out = row_tok_in;
        col_tok_out = col_tok_in;
        for (int i = 0; i < N; i++) begin
            int  col;
            logic win;
            col = wrap_add(int'(diag), N - i, N);
            win = req[i*N + col] & row_tok_in[i] & col_tok_in[col];
            if (win) begin
                stage_grant[i*N + col] = 1'b1;
                row_tok_out[i]         = 1'b0;
                col_tok_out[col]       = 1'b0;
            end
        end
    end

endmodule

// File: rtl/wfa_grant_reg.sv
module wfa_grant_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R8
    grant_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (q == $past(d)));

endmodule

// File: rtl/wavefront_alloc.sv
module wavefront_alloc
    import wfa_pkg::*;
#(
    parameter int N = 4,
    localparam int IW = $clog2(N),
    localparam int CELLS = N * N
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [CELLS-1:0] req,
    output logic [CELLS-1:0] grant,
    output logic [CELLS-1:0] grant_q
);

    logic [IW-1:0]    ptr;
    logic [IW-1:0]    stage_diag  [N];
    logic [N-1:0]     row_tok     [N+1];
    logic [N-1:0]     col_tok     [N+1];
    logic [CELLS-1:0] stage_grant [N];

    wfa_diag_ptr #(.N(N)) ptr_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (enable),
        .ptr    (ptr)
    );

    assign row_tok[0] = '1;
    assign col_tok[0] = '1;

    // The tokens visit the diagonals in order, starting at the pointer.
    for (genvar s = 0; s < N; s++) begin : g_stage
        assign stage_diag[s] = IW'(wrap_add(int'(ptr), s, N));

        wfa_diag_stage #(.N(N)) stage_i (
            .diag        (stage_diag[s]),
            .req         (req),
            .row_tok_in  (row_tok[s]),
            .col_tok_in  (col_tok[s]),
            .stage_grant (stage_grant[s]),
            .row_tok_out (row_tok[s+1]),
            .col_tok_out (col_tok[s+1])
        );
    end

    always_comb begin
        grant = '0;
        for (int s = 0; s < N; s++) grant = grant | stage_grant[s];
    end

    wfa_grant_reg #(.W(CELLS)) greg_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (grant),
        .q     (grant_q)
    );

    // Row and column views of the grants, used by the checks.
    logic [N-1:0] col_bits [N];
    logic [N-1:0] row_any;
    logic [N-1:0] col_any;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) col_bits[j][i] = grant[i*N + j];
        end
        for (int k = 0; k < N; k++) begin
            row_any[k] = |grant[k*N +: N];
            col_any[k] = |col_bits[k];
        end
    end

    // R3
    grant_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~req) == '0);

    for (genvar i = 0; i < N; i++) begin : g_line_chk
        // R1
        row_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(grant[i*N +: N]));
        // R2
        col_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(col_bits[i]));

        for (genvar j = 0; j < N; j++) begin : g_cell_chk
            // R4
            maximal_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (req[i*N + j] && !grant[i*N + j]) |-> (row_any[i] || col_any[j]));
            // R5
            prio_diag_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (int'(ptr) == (i + j) % N && req[i*N + j]) |-> grant[i*N + j]);
        end
    end

endmodule

// File: tb/wavefront_alloc_tb.sv
module wavefront_alloc_tb_top;

    localparam int N = 4;
    localparam int NV = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        enable;
    logic [15:0] req;
    logic [15:0] grant;
    logic [15:0] grant_q;

    int checks = 0;
    int errors = 0;
    int ptr_model = 0;

    always #4 clk = ~clk;

    wavefront_alloc #(.N(N)) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .req     (req),
        .grant   (grant),
        .grant_q (grant_q)
    );

    // {pointer, request, expected grant}; hex digit i is row i.
    localparam logic [33:0] VECS [NV] = '{
        {2'd0, 16'h5137, 16'h4021},  // R6 worked example
        {2'd0, 16'hFFFF, 16'h2481},  // full load, diagonal 0
        {2'd1, 16'hFFFF, 16'h4812},  // full load, diagonal 1
        {2'd2, 16'h0000, 16'h0000},  // no requests
        {2'd2, 16'h5137, 16'h0124},  // example from diagonal 2
        {2'd3, 16'h1111, 16'h1000},  // all want resource 0
        {2'd1, 16'h1111, 16'h0010},  // rotation moves the winner
        {2'd2, 16'h0008, 16'h0008},  // R9 wrap to column 3
        {2'd3, 16'h0013, 16'h0001},  // R9 wrap to diagonal 0
        {2'd1, 16'h0013, 16'h0012}   // both served
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic set_ptr(input int target);
        while (ptr_model != target) begin
            @(negedge clk);
            enable = 1'b1;
            @(posedge clk);
            ptr_model = (ptr_model + 1) % N;
        end
        @(negedge clk);
        enable = 1'b0;
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n  = 1'b0;
        enable = 1'b0;
        req    = '0;
        repeat (3) @(negedge clk);
        #1 check("R8 reset value", grant_q, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            set_ptr(int'(VECS[v][33:32]));
            req = VECS[v][31:16];
            #1 check("R1 R2 R3 R4 R5 R6 R9 vector", grant, VECS[v][15:0]);
            @(negedge clk);
            #1 check("R8 registered", grant_q, VECS[v][15:0]);
        end

        // R10 and R7: enable has no same-cycle effect, then steps and holds.
        set_ptr(0);
        req = 16'hFFFF;
        #1 check("R7 diagonal 0", grant, 16'h2481);
        enable = 1'b1;
        #1 check("R10 enable no same-cycle effect", grant, 16'h2481);
        @(posedge clk);
        ptr_model = 1;
        @(negedge clk);
        enable = 1'b0;
        #1 check("R7 advance", grant, 16'h4812);
        repeat (2) @(negedge clk);
        #1 check("R7 hold", grant, 16'h4812);
        set_ptr(0);
        #1 check("R7 wrap to 0", grant, 16'h2481);

        // R7 and R8: reset in the middle of a run.
        set_ptr(2);
        #1 check("R7 at diagonal 2", grant, 16'h8124);
        rst_n = 1'b0;
        #1 check("R8 async clear", grant_q, 16'h0000);
        check("R7 reset to 0", grant, 16'h2481);
        @(negedge clk);
        rst_n = 1'b1;
        ptr_model = 0;
        @(negedge clk);
        #1 check("R8 after reset", grant_q, 16'h2481);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule